// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one register write into a complete NAND flash bus operation. Software first loads an optional second opcode, two address registers and a data length. It then writes a control word that carries the first opcode, a biased address-cycle count, the chip enable choice and the direction of the data phase. The control word starts the engine. The engine strobes the command latch cycle, the address latch cycles and the data bytes. Where the operation calls for it, it also strobes the second opcode, waits a fixed settle time and then waits for the device's ready line to go high. Completion sets a sticky interrupt flag, and software clears that flag by writing a 1 to it.

Data moves through a byte buffer inside the block. A program operation reads its bytes from the buffer starting at index 0. A read operation stores the bytes it captures at index 0 upward. The host loads and unloads the buffer through its own port between operations. Every bus phase lasts a fixed number of clock cycles set by a parameter.

Top module: `nand_seq_top`

## Requirements
- R1: After reset both chip enables (`nand_ce_n`) are high, `nand_cle`, `nand_ale` and `nand_io_oe` are low, `nand_we_n` and `nand_re_n` are high, and `irq` is low.
- R2: A register write at offset 0 (control) with bit 31 set, made while the engine is idle, starts an operation. The first latch cycle is a command cycle (`nand_cle` high) that carries control bits 7:0. Control bit 19 set drives `nand_ce_n` to 2'b01 (chip 1) for the whole operation. Bit 19 clear drives it to 2'b10.
- R3: Control bits 30:27 set the number of address cycles. When bit 30 is set, the engine issues (bits 29:27)+1 cycles, with a maximum of 5. When bit 30 is clear, it issues none. The bytes go out in this order: offset 2 bits 7:0, offset 2 bits 15:8, offset 3 bits 7:0, offset 3 bits 15:8, offset 3 bits 23:16.
- R4: Offset 1 holds a second opcode in bits 7:0 and an enable in bit 8. When enabled, the engine issues it as a command cycle. With the write bit (control bit 25) clear, this cycle follows the address cycles. With the write bit set, it follows the write data.
- R5: A value N at offset 4 (length) transfers N+1 data bytes. Write data is taken from buffer index 0 upward. Read data is stored at buffer index 0 upward, and buffer entries beyond index N are left unchanged.
- R6: When the second opcode is issued, or when a read phase is requested, the engine waits T_WB clocks and then waits for `nand_rb` to be high. Read strobes (`nand_re_n` low) occur only while `nand_rb` is high.
- R7: When an operation finishes, offset 5 bit 31 becomes set and `irq` goes high. While the engine waits on a low `nand_rb`, neither is set.
- R8: Writing offset 5 with bit 31 set clears the flag. Writing it with bit 31 clear leaves the flag set.
- R9: A control write made while the engine is busy is ignored. It issues no extra bus cycles, it does not disturb the running operation, and reading offset 0 afterwards still returns the accepted word.
- R10: `nand_cle` and `nand_ale` are never high together, and `nand_we_n` and `nand_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_addr` |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | AW | Host buffer index |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_rdata | output | 8 | Host buffer byte at `buf_addr` |
| irq | output | 1 | Completion interrupt flag |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, data latched on its rising edge |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Output enable for `nand_io_out` |
| nand_io_in | input | 8 | Byte from the flash |
| nand_rb | input | 1 | Ready (high) / busy (low) from the flash |

## Verification
The assertions assume that the host changes the second-opcode, address and length registers only while the engine is idle. They also assume that the host never writes the buffer in the same cycle as a read capture, and that `nand_rb` always returns high. The bench loads every register and buffer entry before the control write, and it unloads the buffer only after the interrupt. Its flash model holds `nand_rb` low for a bounded 20 clocks after each second opcode that implies device activity. The only write it makes during an operation is the control write that must be ignored.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_WDATA, ST_CMD2,
    ST_TWB, ST_RB, ST_RDATA, ST_DONE
  } seq_state_t;

  localparam int unsigned MAX_ADDR_CYC = 5;

  // biased field: bit 3 = present, bits 2:0 = cycles-1, capped
  function automatic logic [2:0] addr_cycles(input logic [3:0] fld);
    if (!fld[3]) return 3'd0;
    if (fld[2:0] >= 3'(MAX_ADDR_CYC - 1)) return 3'(MAX_ADDR_CYC);
    return fld[2:0] + 3'd1;
  endfunction

  // byte k of the concatenated address registers
  function automatic logic [7:0] addr_byte(input logic [15:0] lo,
                                           input logic [23:0] hi,
                                           input logic [2:0]  idx);
    case (idx)
      3'd0:    return lo[7:0];
      3'd1:    return lo[15:8];
      3'd2:    return hi[7:0];
      3'd3:    return hi[15:8];
      default: return hi[23:16];
    endcase
  endfunction

endpackage

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [7:0]    e_wdata,
  output logic [7:0]    e_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (e_we)      mem[e_addr] <= e_wdata;
    else if (h_we) mem[h_addr] <= h_wdata;
  end

  assign h_rdata = mem[h_addr];
  assign e_rdata = mem[e_addr];

  // R5: host and engine never write the buffer in the same cycle
  port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_we |-> !h_we);
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs #(
  parameter int DLEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              busy,
  input  logic              done_evt,
  output logic              start,
  output logic [31:0]       ctrl_q,
  output logic [8:0]        cmd2_q,
  output logic [15:0]       addr_lo_q,
  output logic [23:0]       addr_hi_q,
  output logic [DLEN_W-1:0] dlen_q,
  output logic              irq_q
);
  logic ctrl_wr, irq_clr;

  assign ctrl_wr = wr_en && (addr == 3'd0) && !busy;
  assign start   = ctrl_wr && wr_data[31];
  assign irq_clr = wr_en && (addr == 3'd5) && wr_data[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cmd2_q    <= '0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      dlen_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data;
      if (wr_en && addr == 3'd1) cmd2_q    <= wr_data[8:0];
      if (wr_en && addr == 3'd2) addr_lo_q <= wr_data[15:0];
      if (wr_en && addr == 3'd3) addr_hi_q <= wr_data[23:0];
      if (wr_en && addr == 3'd4) dlen_q    <= wr_data[DLEN_W-1:0];
      if (done_evt)     irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = ctrl_q;
      3'd1:    rd_data = {23'd0, cmd2_q};
      3'd2:    rd_data = {16'd0, addr_lo_q};
      3'd3:    rd_data = {8'd0, addr_hi_q};
      3'd4:    rd_data = {{(32-DLEN_W){1'b0}}, dlen_q};
      3'd5:    rd_data = {irq_q, 31'd0};
      default: rd_data = '0;
    endcase
  end

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == 3'd0) |=> $stable(ctrl_q));
  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq_q);
  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !done_evt) |=> !irq_q);
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int T_LO   = 2,
  parameter int T_HI   = 2,
  parameter int T_WB   = 4,
  parameter int DLEN_W = 12,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_word,
  input  logic [8:0]        cmd2_q,
  input  logic [15:0]       addr_lo_q,
  input  logic [23:0]       addr_hi_q,
  input  logic [DLEN_W-1:0] dlen_q,
  input  logic              nand_rb,
  input  logic [7:0]        nand_io_in,
  input  logic [7:0]        buf_rdata,
  output logic [AW-1:0]     buf_idx,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [1:0]        nand_ce_n,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  output logic              busy,
  output logic              done_evt
);
  localparam logic [15:0] CYC_LAST = 16'(T_LO + T_HI - 1);
  localparam logic [15:0] LO_LAST  = 16'(T_LO - 1);
  localparam logic [15:0] WB_LAST  = 16'(T_WB - 1);
  localparam logic [15:0] LO_CNT   = 16'(T_LO);

  seq_state_t st, nxt, after_addr;
  logic [15:0]       ph;
  logic [2:0]        acnt, naddr;
  logic [DLEN_W-1:0] dcnt;
  logic [7:0]        j_op;
  logic [3:0]        j_afld;
  logic              j_rd, j_wr, j_cs1;
  logic              bus_st, cyc_end, strobe_lo;

  assign naddr     = addr_cycles(j_afld);
  assign bus_st    = (st == ST_CMD1) || (st == ST_ADDR) || (st == ST_WDATA) ||
                     (st == ST_CMD2) || (st == ST_RDATA);
  assign cyc_end   = bus_st && (ph == CYC_LAST);
  assign strobe_lo = ph < LO_CNT;

  always_comb begin
    if (j_wr)           after_addr = ST_WDATA;
    else if (cmd2_q[8]) after_addr = ST_CMD2;
    else if (j_rd)      after_addr = ST_TWB;
    else                after_addr = ST_DONE;
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (start) nxt = ST_CMD1;
      ST_CMD1:  if (cyc_end) nxt = (naddr != 3'd0) ? ST_ADDR : after_addr;
      ST_ADDR:  if (cyc_end && acnt == naddr - 3'd1) nxt = after_addr;
      ST_WDATA: if (cyc_end && dcnt == dlen_q) nxt = cmd2_q[8] ? ST_CMD2 : ST_DONE;
      ST_CMD2:  if (cyc_end) nxt = ST_TWB;
      ST_TWB:   if (ph == WB_LAST) nxt = ST_RB;
      ST_RB:    if (nand_rb) nxt = (j_rd && !j_wr) ? ST_RDATA : ST_DONE;
      ST_RDATA: if (cyc_end && dcnt == dlen_q) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ph     <= '0;
      acnt   <= '0;
      dcnt   <= '0;
      j_op   <= '0;
      j_afld <= '0;
      j_rd   <= 1'b0;
      j_wr   <= 1'b0;
      j_cs1  <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st || cyc_end) ph <= '0;
      else                      ph <= ph + 16'd1;
      if (st == ST_IDLE && start) begin
        j_op   <= start_word[7:0];
        j_afld <= start_word[30:27];
        j_rd   <= start_word[26];
        j_wr   <= start_word[25];
        j_cs1  <= start_word[19];
        acnt   <= '0;
        dcnt   <= '0;
      end else begin
        if (st == ST_ADDR && cyc_end) acnt <= acnt + 3'd1;
        if ((st == ST_WDATA || st == ST_RDATA) && cyc_end) dcnt <= dcnt + 1'b1;
      end
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done_evt = (st == ST_DONE);

  assign nand_cle    = (st == ST_CMD1) || (st == ST_CMD2);
  assign nand_ale    = (st == ST_ADDR);
  assign nand_io_oe  = nand_cle || nand_ale || (st == ST_WDATA);
  assign nand_we_n   = !(nand_io_oe && strobe_lo);
  assign nand_re_n   = !((st == ST_RDATA) && strobe_lo);
  assign nand_ce_n   = busy ? (j_cs1 ? 2'b01 : 2'b10) : 2'b11;

  always_comb begin
    case (st)
      ST_CMD1:  nand_io_out = j_op;
      ST_CMD2:  nand_io_out = cmd2_q[7:0];
      ST_ADDR:  nand_io_out = addr_byte(addr_lo_q, addr_hi_q, acnt);
      ST_WDATA: nand_io_out = buf_rdata;
      default:  nand_io_out = 8'd0;
    endcase
  end

  assign buf_idx   = AW'(dcnt);
  assign buf_we    = (st == ST_RDATA) && (ph == LO_LAST);
  assign buf_wdata = nand_io_in;

  // checker-side strobe counters
  logic [DLEN_W:0] xfer_seen;
  logic [2:0]      ale_seen;
  logic            data_start, ale_start, job_data;
  assign data_start = (st == ST_WDATA || st == ST_RDATA) && ph == 16'd0;
  assign ale_start  = (st == ST_ADDR) && ph == 16'd0;
  assign job_data   = j_wr || j_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_seen <= '0;
      ale_seen  <= '0;
    end else if (st == ST_IDLE && start) begin
      xfer_seen <= '0;
      ale_seen  <= '0;
    end else begin
      if (data_start) xfer_seen <= xfer_seen + 1'b1;
      if (ale_start)  ale_seen  <= ale_seen + 3'd1;
    end
  end

  // R2
  start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (nand_cle && !nand_ale));
  // R3
  addr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (ale_seen == naddr));
  // R5
  xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && job_data) |-> (xfer_seen == {1'b0, dlen_q} + 1'b1));
  // R6
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RB && !nand_rb) |=> (st == ST_RB));
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top #(
  parameter int BUF_DEPTH = 64,
  parameter int DLEN_W    = 12,
  parameter int T_LO      = 2,
  parameter int T_HI      = 2,
  parameter int T_WB      = 4,
  localparam int AW = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic          irq,
  output logic [1:0]    nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [7:0]    nand_io_out,
  output logic          nand_io_oe,
  input  logic [7:0]    nand_io_in,
  input  logic          nand_rb
);
  logic              start, busy, done_evt;
  logic [31:0]       ctrl_q;
  logic [8:0]        cmd2_q;
  logic [15:0]       addr_lo_q;
  logic [23:0]       addr_hi_q;
  logic [DLEN_W-1:0] dlen_q;
  logic [AW-1:0]     e_idx;
  logic              e_we;
  logic [7:0]        e_wdata, e_rdata;

  nand_seq_regs #(.DLEN_W(DLEN_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .busy(busy),
    .done_evt(done_evt), .start(start), .ctrl_q(ctrl_q),
    .cmd2_q(cmd2_q), .addr_lo_q(addr_lo_q), .addr_hi_q(addr_hi_q),
    .dlen_q(dlen_q), .irq_q(irq)
  );

  nand_seq_fsm #(.T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB),
                 .DLEN_W(DLEN_W), .AW(AW)) i_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_word(reg_wdata),
    .cmd2_q(cmd2_q), .addr_lo_q(addr_lo_q), .addr_hi_q(addr_hi_q),
    .dlen_q(dlen_q), .nand_rb(nand_rb), .nand_io_in(nand_io_in),
    .buf_rdata(e_rdata), .buf_idx(e_idx), .buf_we(e_we),
    .buf_wdata(e_wdata), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .busy(busy), .done_evt(done_evt)
  );

  nand_seq_buf #(.DEPTH(BUF_DEPTH)) i_buf (
    .clk(clk), .rst_n(rst_n), .h_we(buf_we), .h_addr(buf_addr),
    .h_wdata(buf_wdata), .h_rdata(buf_rdata), .e_we(e_we),
    .e_addr(e_idx), .e_wdata(e_wdata), .e_rdata(e_rdata)
  );

  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_q;
endmodule

// File: tb/test_nand_seq_top.sv
module test_nand_seq_top;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic buf_we = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata;
  logic irq, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [1:0] nand_ce_n;
  logic [7:0] nand_io_out, nand_io_in;
  logic nand_rb = 1'b1;

  always #5 clk = ~clk;

  nand_seq_top i_nand_seq_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .irq(irq), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---- flash model ----
  int rcount = 0, rbase = 0;
  function automatic logic [7:0] rd_pat(input int i);
    return 8'(8'h3C + i * 11);
  endfunction
  function automatic logic [7:0] wr_pat(input int i);
    return 8'(8'hC1 ^ (i * 5));
  endfunction
  assign nand_io_in = rd_pat(rcount - rbase);
  always @(posedge nand_re_n) if (rst_n) rcount++;

  event kick_ev;
  int rb_irq_bad = 0, r6_bad = 0, r10_bad = 0;
  always begin
    @(kick_ev);
    nand_rb = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (irq) rb_irq_bad++;
    end
    nand_rb = 1'b1;
  end
  always @(negedge nand_re_n) if (rst_n && !nand_rb) r6_bad++;
  always @(negedge clk)
    if (rst_n && ((nand_cle && nand_ale) || (!nand_we_n && !nand_re_n))) r10_bad++;

  // ---- scoreboard ----
  typedef struct { logic [1:0] k; logic [7:0] b; string req; } item_t;
  item_t exp_q[$];
  logic [1:0] exp_ce = 2'b11;

  task automatic push(input logic [1:0] k, input logic [7:0] b, input string req);
    item_t it;
    it.k = k; it.b = b; it.req = req;
    exp_q.push_back(it);
  endtask

  always @(posedge nand_we_n) begin
    #1;
    if (rst_n) begin
      logic [1:0] k;
      k = nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd3);
      if (exp_q.size() == 0)
        chk(1'b0, "R9 unexpected latch cycle", {22'd0, k, nand_io_out}, 32'd0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        chk(k == e.k && nand_io_out == e.b, e.req, {22'd0, k, nand_io_out}, {22'd0, e.k, e.b});
      end
      chk(nand_ce_n == exp_ce, "R2 chip enable", {30'd0, nand_ce_n}, {30'd0, exp_ce});
      if (nand_cle && (nand_io_out == 8'h10 || nand_io_out == 8'h30 || nand_io_out == 8'hD0))
        -> kick_ev;
    end
  end

  // ---- driver ----
  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic buf_write(input int i, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_addr = AW'(i); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic buf_read(input int i, output logic [7:0] d);
    @(negedge clk);
    buf_addr = AW'(i);
    #1 d = buf_rdata;
  endtask

  function automatic int exp_naddr(input logic [3:0] f);
    int n;
    if (f[3] == 1'b0) return 0;
    n = int'(f[2:0]) + 1;
    return (n > 5) ? 5 : n;
  endfunction

  function automatic logic [7:0] exp_abyte(input logic [15:0] lo, input logic [23:0] hi, input int k);
    logic [39:0] all;
    all = {hi, lo};
    return all[8*k +: 8];
  endfunction

  task automatic wait_done();
    int t;
    t = 0;
    while (!irq && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!irq) chk(1'b0, "R7 completion timeout", 32'd0, 32'd1);
  endtask

  task automatic run_job(input logic [7:0] op, input logic [3:0] af, input bit rd, input bit wr,
                         input bit cs1, input bit c2en, input logic [7:0] c2op,
                         input logic [15:0] lo, input logic [23:0] hi, input int n,
                         input bit poke_busy);
    logic [31:0] ctrl, r;
    logic [7:0] b;
    if (wr) for (int i = 0; i <= n; i++) buf_write(i, wr_pat(i));
    if (rd) buf_write(n + 1, 8'h5A);
    rbase = rcount;
    push(2'd1, op, "R2 first command");
    for (int k = 0; k < exp_naddr(af); k++) push(2'd2, exp_abyte(lo, hi, k), "R3 address byte");
    if (wr) for (int i = 0; i <= n; i++) push(2'd3, wr_pat(i), "R5 write data");
    if (c2en) push(2'd1, c2op, "R4 second command");
    exp_ce = cs1 ? 2'b01 : 2'b10;
    reg_write(3'd1, {23'd0, c2en, c2op});
    reg_write(3'd2, {16'd0, lo});
    reg_write(3'd3, {8'd0, hi});
    reg_write(3'd4, n);
    ctrl = {1'b1, af, rd, wr, 5'd0, cs1, 11'd0, op};
    reg_write(3'd0, ctrl);
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      reg_write(3'd0, 32'h8000_00EE);
    end
    wait_done();
    chk(exp_q.size() == 0, "R3 all latch cycles issued", exp_q.size(), 32'd0);
    exp_q.delete();
    if (rd) begin
      for (int i = 0; i <= n; i++) begin
        buf_read(i, b);
        chk(b == rd_pat(i), "R5 read byte", {24'd0, b}, {24'd0, rd_pat(i)});
      end
      buf_read(n + 1, b);
      chk(b == 8'h5A, "R5 byte beyond length untouched", {24'd0, b}, 32'h5A);
    end
    if (poke_busy) begin
      reg_read(3'd0, r);
      chk(r == ctrl, "R9 control kept", r, ctrl);
    end
    reg_read(3'd5, r);
    chk(r[31] && irq, "R7 done flag", r, 32'h8000_0000);
    reg_write(3'd5, 32'd0);
    reg_read(3'd5, r);
    chk(r[31], "R8 write of 0 keeps flag", r, 32'h8000_0000);
    reg_write(3'd5, 32'h8000_0000);
    reg_read(3'd5, r);
    chk(!r[31] && !irq, "R8 write of 1 clears flag", r, 32'd0);
    exp_ce = 2'b11;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(nand_ce_n == 2'b11, "R1 ce_n", {30'd0, nand_ce_n}, 32'd3);
    chk(!nand_cle && !nand_ale && !nand_io_oe, "R1 latches", {29'd0, nand_cle, nand_ale, nand_io_oe}, 32'd0);
    chk(nand_we_n && nand_re_n && !irq, "R1 strobes", {29'd0, nand_we_n, nand_re_n, irq}, 32'd6);

    // ID read: 1 address cycle, 5 bytes, chip 0
    run_job(8'h90, 4'b1000, 1, 0, 0, 0, 8'h00, 16'h0000, 24'h0, 4, 0);
    // page read with confirm, 5 address cycles, chip 1
    run_job(8'h00, 4'b1100, 1, 0, 1, 1, 8'h30, 16'h1234, 24'hABCDEF, 7, 0);
    // program: data then confirm
    run_job(8'h80, 4'b1100, 0, 1, 0, 1, 8'h10, 16'h0040, 24'h000102, 9, 0);
    // erase: 3 address cycles, no data
    run_job(8'h60, 4'b1010, 0, 0, 1, 1, 8'hD0, 16'h5678, 24'h00009A, 0, 0);
    // reset opcode: field bit 3 clear, no address cycles
    run_job(8'hFF, 4'b0111, 0, 0, 0, 0, 8'h00, 16'hFFFF, 24'hFFFFFF, 0, 0);
    // field 7 capped at 5 cycles, no second opcode
    run_job(8'h85, 4'b1111, 0, 0, 0, 0, 8'h00, 16'hA1B2, 24'hC3D4E5, 0, 0);
    // busy control write ignored
    run_job(8'h80, 4'b1011, 0, 1, 1, 1, 8'h10, 16'h0F0E, 24'h0D0C0B, 20, 1);

    chk(r6_bad == 0, "R6 read strobe while busy", r6_bad, 32'd0);
    chk(rb_irq_bad == 0, "R7 flag set while ready low", rb_irq_bad, 32'd0);
    chk(r10_bad == 0, "R10 strobe exclusivity", r10_bad, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule